// File: doc/BRIEF.md
# Fractional Clock Enable Controller

This block produces a clock-enable stream whose average rate is the input clock rate times `mult / 32`, further divided by a fixed per-instance post-divider. Within each 32-cycle window it passes exactly `mult` input cycles, and an accumulator spreads them as evenly as it can. Downstream logic gates its registers with `clk_en` to run at the reduced rate.

Software sets the ratio through a two-register port. It first writes a 5-bit field that holds `32 - mult` into the ratio register, so a field of 0 means full rate. It then sets the commit bit in a second register. A three-state machine (`ST_IDLE`, `ST_ARMED`, `ST_SWITCH`) tracks the commit. A commit write in `ST_IDLE` moves to `ST_ARMED`. At the last cycle of the current window, `ST_ARMED` loads the new ratio and moves to `ST_SWITCH`. One cycle later `ST_SWITCH` returns to `ST_IDLE`, which clears the commit bit. While the commit bit reads as set, ratio writes are refused and flagged.

Top module: `frac_clk_ctl`

## Requirements
- R1: After reset the ratio field reads 0, the commit bit and `busy` read 0, `wr_reject` is 0, and the active multiplier is 32 (full rate).
- R2: With active multiplier m (1..32), a fractional pulse occurs at window phase k (0..31) exactly when floor((k+1)·m/32) > floor(k·m/32). This gives m pulses in every 32-cycle window.
- R3: `clk_en` is registered. It is high one cycle after every POST_DIV-th fractional pulse, counted from reset.
- R4: The ratio register (`wr_sel`/`rd_sel` = 0) holds the field in bits FIELD_LSB+4..FIELD_LSB. A read returns the last accepted field value, whether or not it has been committed. All other bits read 0.
- R5: Writing the ratio field alone does not change the output pattern.
- R6: The commit register (`sel` = 1) has its commit bit at bit 31. Writing a 1 there while idle sets the bit, and `busy` mirrors it. The commit bit is only set by such a write.
- R7: A ratio write while `busy` is high leaves the stored field unchanged. `wr_reject` is high in the following cycle exactly when a write was refused.
- R8: A committed ratio becomes active at the start of the window that follows the commit. The commit bit clears one cycle after that window boundary, at phase 1.
- R9: A write to the commit register with bit 31 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 ratio, 1 commit |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 ratio, 1 commit |
| rd_data | output | 32 | Read data (combinational) |
| busy | output | 1 | Commit bit still set |
| wr_reject | output | 1 | Pulse: previous ratio write refused |
| clk_en | output | 1 | Gated clock-enable output |

## Verification
The bench builds the block with FIELD_LSB = 12 and POST_DIV = 3. The non-zero offset shows that the field is decoded at its parameterised position and that the junk written around it is masked. A post-divider of 3 makes the divider counter wrap across window boundaries and ratio changes. This brings into reach the pulse phase that is carried across a switch from m = 12 to m = 1 and back to full rate. Refused writes issued during the armed wait, and the exact cycle in which the commit bit clears, are compared against a behavioural model on every clock.

// File: rtl/frac_clk_pkg.sv
package frac_clk_pkg;
    localparam int FIELD_W  = 5;
    localparam int WIN_LEN  = 1 << FIELD_W;
    localparam int MULT_W   = FIELD_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_SWITCH = 2'd2
    } kick_state_t;
endpackage

// File: rtl/frac_clk_regs.sv
module frac_clk_regs
    import frac_clk_pkg::*;
#(
    parameter int FIELD_LSB = 8,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              window_end,
    output logic              busy,
    output logic              wr_reject,
    output logic              commit,
    output logic [MULT_W-1:0] commit_mult
);
    localparam int KICK_BIT = DATA_W - 1;

    kick_state_t state_q, state_d;
    logic [FIELD_W-1:0] field_q;
    logic ratio_wr, kick_wr;

    assign ratio_wr = wr_en && !wr_sel;
    assign kick_wr  = wr_en && wr_sel && wr_data[KICK_BIT];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (kick_wr)    state_d = ST_ARMED;
            ST_ARMED:  if (window_end) state_d = ST_SWITCH;
            ST_SWITCH:                 state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy   = 1'b1;
        commit = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_ARMED:  commit = window_end;
            ST_SWITCH: busy = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field_q   <= '0;
            wr_reject <= 1'b0;
        end else begin
            wr_reject <= ratio_wr && busy;
            if (ratio_wr && !busy)
                field_q <= wr_data[FIELD_LSB +: FIELD_W];
        end
    end

    assign commit_mult = MULT_W'(WIN_LEN) - {1'b0, field_q};

    always_comb begin
        rd_data = '0;
        if (rd_sel) rd_data[KICK_BIT] = busy;
        else        rd_data[FIELD_LSB +: FIELD_W] = field_q;
    end
endmodule

// File: rtl/frac_clk_accum.sv
module frac_clk_accum
    import frac_clk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [MULT_W-1:0] commit_mult,
    output logic              window_end,
    output logic              frac_pulse,
    output logic [FIELD_W-1:0] phase,
    output logic [MULT_W-1:0] mult_act
);
    logic [FIELD_W-1:0] acc_q, phase_q;
    logic [MULT_W-1:0]  mult_q, sum;

    assign sum        = {1'b0, acc_q} + mult_q;
    assign frac_pulse = sum[MULT_W-1];
    assign window_end = &phase_q;
    assign phase      = phase_q;
    assign mult_act   = mult_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            phase_q <= '0;
            mult_q  <= MULT_W'(WIN_LEN);
        end else begin
            phase_q <= phase_q + 1'b1;
            acc_q   <= sum[FIELD_W-1:0];
            if (commit) mult_q <= commit_mult;
        end
    end
endmodule

// File: rtl/frac_clk_postdiv.sv
module frac_clk_postdiv #(
    parameter int POST_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    output logic en_out
);
    generate
        if (POST_DIV <= 1) begin : g_bypass
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) en_out <= 1'b0;
                else        en_out <= pulse_in;
            end
        end else begin : g_count
            localparam int CNT_W = $clog2(POST_DIV);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(POST_DIV - 1);
            logic [CNT_W-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q  <= '0;
                    en_out <= 1'b0;
                end else begin
                    en_out <= pulse_in && (cnt_q == LAST);
                    if (pulse_in)
                        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/frac_clk_ctl.sv
module frac_clk_ctl
    import frac_clk_pkg::*;
#(
    parameter int FIELD_LSB = 8,
    parameter int POST_DIV  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    input  logic        rd_sel,
    output logic [31:0] rd_data,
    output logic        busy,
    output logic        wr_reject,
    output logic        clk_en
);
    logic               window_end, commit, frac_pulse;
    logic [MULT_W-1:0]  commit_mult, mult_act;
    logic [FIELD_W-1:0] phase;

    frac_clk_regs #(.FIELD_LSB(FIELD_LSB), .DATA_W(32)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .window_end(window_end), .busy(busy), .wr_reject(wr_reject),
        .commit(commit), .commit_mult(commit_mult)
    );

    frac_clk_accum u_acc (
        .clk(clk), .rst_n(rst_n), .commit(commit), .commit_mult(commit_mult),
        .window_end(window_end), .frac_pulse(frac_pulse),
        .phase(phase), .mult_act(mult_act)
    );

    frac_clk_postdiv #(.POST_DIV(POST_DIV)) u_pdiv (
        .clk(clk), .rst_n(rst_n), .pulse_in(frac_pulse), .en_out(clk_en)
    );
endmodule

// File: rtl/frac_clk_ctl_chk.sv
module frac_clk_ctl_chk #(
    parameter int POST_DIV = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [31:0] wr_data,
    input logic       busy,
    input logic       wr_reject,
    input logic       clk_en,
    input logic       frac_pulse,
    input logic [4:0] phase,
    input logic [5:0] mult_act
);
    p_kick_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(wr_en && wr_sel && wr_data[31])) |=> !busy)
        else $error("commit bit set without a write");

    p_no_kick_on_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && wr_sel && !wr_data[31]) |=> !busy)
        else $error("commit write with bit 31 clear took effect");

    p_reject_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && busy) |=> wr_reject)
        else $error("refused write not flagged");

    p_reject_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> $past(wr_en && !wr_sel && busy))
        else $error("spurious reject flag");

    p_switch_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mult_act) |-> ($past(phase) == 5'd31))
        else $error("ratio changed mid-window");

    p_clear_after_switch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (phase == 5'd1))
        else $error("commit bit cleared at wrong phase");

    p_full_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mult_act == 6'd32) |-> frac_pulse)
        else $error("full rate missed a pulse");

    generate
        if (POST_DIV > 1) begin : g_pd
            p_spaced_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
                clk_en |=> !clk_en)
                else $error("post-divided enable high twice in a row");
        end
    endgenerate
endmodule

bind frac_clk_ctl frac_clk_ctl_chk #(.POST_DIV(POST_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .busy(busy), .wr_reject(wr_reject), .clk_en(clk_en),
    .frac_pulse(frac_pulse), .phase(phase), .mult_act(mult_act)
);

// File: tb/frac_clk_ctl_bench.sv
`timescale 1ns/1ps
module frac_clk_ctl_bench;
    localparam int LSB = 12;
    localparam int PD  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        busy, wr_reject, clk_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit done = 0;

    // behavioural model state
    int m_mult = 32, m_pend = 0, m_st = 0, m_phase = 0, m_pd = 0;
    bit e_en = 0, e_rej = 0;

    always #2.5 clk = ~clk;

    frac_clk_ctl #(.FIELD_LSB(LSB), .POST_DIV(PD)) u_frac_clk_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .busy(busy), .wr_reject(wr_reject), .clk_en(clk_en)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mult = 32; m_pend = 0; m_st = 0; m_phase = 0; m_pd = 0;
            e_en = 0; e_rej = 0;
        end else begin
            bit frac;
            frac = (((m_phase + 1) * m_mult) / 32) > ((m_phase * m_mult) / 32);
            e_en = frac && (m_pd == PD - 1);
            if (frac) m_pd = (m_pd + 1) % PD;
            e_rej = wr_en && !wr_sel && (m_st != 0);
            if (wr_en && !wr_sel && m_st == 0)
                m_pend = int'((wr_data >> LSB) & 32'h1F);
            if (m_st == 0) begin
                if (wr_en && wr_sel && wr_data[31]) m_st = 1;
            end else if (m_st == 1) begin
                if (m_phase == 31) begin
                    m_mult = 32 - m_pend;
                    m_st = 2;
                end
            end else begin
                m_st = 0;
            end
            m_phase = (m_phase + 1) % 32;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) rd_sel <= ~rd_sel;

    // per-cycle comparison against the model
    always begin
        @(negedge clk);
        #1;
        if (rst_n && started && !done) begin
            chk("R2/R3 clk_en", {31'b0, clk_en}, {31'b0, e_en});
            chk("R6/R8 busy", {31'b0, busy}, {31'b0, (m_st != 0)});
            chk("R7 wr_reject", {31'b0, wr_reject}, {31'b0, e_rej});
            if (rd_sel) chk("R6 commit read", rd_data, {(m_st != 0), 31'b0});
            else        chk("R4 ratio read", rd_data, 32'(m_pend) << LSB);
        end
    end

    task automatic wr(input bit sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int cnt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        started = 1;
        @(negedge clk); #2;
        // R1: reset state
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 reject", {31'b0, wr_reject}, 32'd0);
        repeat (40) @(negedge clk);
        // R4/R5: field with junk around it, no commit
        wr(1'b0, (32'hFFFF_FFFF & ~(32'h1F << LSB)) | (32'd20 << LSB));
        repeat (40) @(negedge clk);
        // R6/R8: commit m = 12
        wr(1'b1, 32'h8000_0000);
        wait_idle();
        // R2: 96 cycles at m = 12 give 36 fractional pulses, so 12 enables
        cnt = 0;
        for (int i = 0; i < 96; i++) begin
            @(negedge clk); #2;
            if (clk_en) cnt++;
        end
        chk("R2 enable count", 32'(cnt), 32'd12);
        // R7: refused write while armed
        wr(1'b0, 32'd31 << LSB);
        wr(1'b1, 32'h8000_0000);
        wr(1'b0, 32'd5 << LSB);
        wait_idle();
        repeat (70) @(negedge clk);
        // R9: commit register write with bit 31 clear
        wr(1'b0, 32'd16 << LSB);
        wr(1'b1, 32'h7FFF_FFFF);
        #2;
        chk("R9 busy stays low", {31'b0, busy}, 32'd0);
        repeat (40) @(negedge clk);
        wr(1'b1, 32'h8000_0000);
        wait_idle();
        repeat (70) @(negedge clk);
        // back to full rate, then m = 25
        wr(1'b0, 32'd0);
        wr(1'b1, 32'h8000_0000);
        wait_idle();
        repeat (50) @(negedge clk);
        wr(1'b0, 32'd7 << LSB);
        wr(1'b1, 32'h8000_0000);
        wait_idle();
        repeat (80) @(negedge clk);
        finish_run();
    end
endmodule